// File: doc/BRIEF.md
# Register-Mapped GPIO Expander Core

This block is the register file and pin logic of an eight-pin general-purpose I/O expander. A host reaches it through a byte-wide register port. Each access names an 8-bit register index. A write takes effect at the clock edge on which it is strobed. A read returns its data combinationally in the same cycle, and any clear-on-read side effect lands at the edge that closes that cycle. The serial bus slave that would normally sit in front of this port is not part of the block.

Per pin, the core holds these settings:
- whether the pin is an output;
- the level it drives when it is an output;
- a driver tri-state override;
- the level the input is expected to sit at;
- whether a pull is enabled, and whether that pull is up or down;
- whether the pin may raise the interrupt.

The pin levels pass through a two-stage synchronizer. When a synchronized level differs from the expected level, the core latches a status bit for that pin. The status register clears when it is read. An active-low interrupt line is asserted while any unmasked status bit is set, or while a power-on flag is set.

An identification register reports a fixed manufacturer code and a revision number. It also carries the power-on flag, which a read of that register clears. Writing a one to the lowest bit of the identification register performs a soft reset, which returns every setting to its power-up value.

Top module: `gpio_xpdr_core`

## Requirements
- R1: Seven read/write registers read back the last value written, at these indices: direction 0x03, output level 0x05, tri-state 0x07, expected input 0x09, pull enable 0x0B, pull select 0x0D and interrupt mask 0x11.
- R2: For each pin i, `pin_oe[i]` equals direction[i] AND NOT tri-state[i], where a direction bit of 1 means output. `pin_out[i]` equals output-level[i] while `pin_oe[i]` is 1, and 0 otherwise.
- R3: After reset, the register values are:
  - direction 0x00 and output level 0x00;
  - tri-state 0xFF, expected input 0xFF, pull enable 0xFF and pull select 0xFF;
  - interrupt mask 0xFF;
  - interrupt status 0x00.
- R4: For each pin i, `pull_en[i]` equals NOT direction[i] AND pull-enable[i]. `pull_up[i]` equals `pull_en[i]` AND pull-select[i], so a pull-select bit of 1 chooses pull-up and 0 chooses pull-down.
- R5: Index 0x0F reads the pin levels as they stood two clock edges earlier. A status bit is set at the edge after its synchronized level differs from its expected bit. A set status bit stays set until the status register is read.
- R6: Reading index 0x13 returns the status and clears it at the end of that cycle. A mismatch that is still present during the clearing read sets its bit again in the same update, so the next read still shows it.
- R7: A mask bit of 1 blocks its pin from the interrupt. `irq_n` is low whenever status AND NOT mask is nonzero, and a masked status bit alone leaves `irq_n` high.
- R8: Reset sets the power-on flag. `irq_n` is low while the flag is set, regardless of the mask.
- R9: Index 0x01 reads as follows:
  - bits 7:5 hold the manufacturer code 0b101;
  - bits 4:2 hold the revision parameter (default 1);
  - bit 1 holds the power-on flag;
  - bit 0 reads 0.

  With defaults this gives 0xA6 while the flag is set. Reading index 0x01 clears the flag.
- R10: Writing a value with bit 0 set to index 0x01 restores every R3 value and sets the power-on flag again.
- R11: Writes to 0x0F, to 0x13 and to unmapped indices change nothing. Reads of unmapped indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe; enables the clear-on-read side effects |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| pin_in | input | 8 | Pin levels as seen from outside |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin driven level |
| pull_en | output | 8 | Per-pin pull resistor enable |
| pull_up | output | 8 | Per-pin pull direction, 1 = up |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a status read that coincides with a mismatch that is still live. In that case the bit must clear and then reappear, and it must never be lost. The bench gets there by holding one unmasked pin away from its expected level through the synchronizer delay and reading the status twice in succession. It then restores the pin and reads twice more, to show that the bit stays set after the cause has gone and that it clears only on a read. A sweep of all 256 pin patterns, with the second of two back-to-back reads checked each time, covers the same situation on every pin.

// File: rtl/gpio_xpdr_pkg.sv
package gpio_xpdr_pkg;
  localparam int NPIN = 8;
  localparam int AW   = 8;
  localparam int NREG = 7;

  typedef logic [NPIN-1:0] pinvec_t;
  typedef logic [AW-1:0]   addr_t;

  localparam addr_t A_ID    = 8'h01;
  localparam addr_t A_INSTS = 8'h0F;
  localparam addr_t A_STAT  = 8'h13;

  // read/write register slots
  localparam int I_DIR   = 0;
  localparam int I_OUT   = 1;
  localparam int I_HIZ   = 2;
  localparam int I_EXP   = 3;
  localparam int I_PEN   = 4;
  localparam int I_PSEL  = 5;
  localparam int I_MASK  = 6;

  localparam logic [2:0] MFR_CODE = 3'b101;

  function automatic addr_t slot_addr(input int idx);
    case (idx)
      I_DIR:   return 8'h03;
      I_OUT:   return 8'h05;
      I_HIZ:   return 8'h07;
      I_EXP:   return 8'h09;
      I_PEN:   return 8'h0B;
      I_PSEL:  return 8'h0D;
      default: return 8'h11;
    endcase
  endfunction

  function automatic pinvec_t slot_dflt(input int idx);
    case (idx)
      I_DIR, I_OUT: return '0;
      default:      return '1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_xpdr_sync.sv
module gpio_xpdr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_rest
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_xpdr_regs.sv
module gpio_xpdr_regs
  import gpio_xpdr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      addr,
  input  pinvec_t                    wdata,
  input  logic                       soft_rst,
  output logic [NREG-1:0][NPIN-1:0]  cfg_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam addr_t   MY_ADDR = slot_addr(g);
    localparam pinvec_t MY_DFLT = slot_dflt(g);
    pinvec_t val_d, val_q;
    logic    hit;

    assign hit = wr_en && (addr == MY_ADDR);

    always_comb begin
      val_d = val_q;
      if (soft_rst)  val_d = MY_DFLT;
      else if (hit)  val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= MY_DFLT;
      else        val_q <= val_d;
    end

    assign cfg_o[g] = val_q;
  end
endmodule

// File: rtl/gpio_xpdr_pins.sv
module gpio_xpdr_pins
  import gpio_xpdr_pkg::*;
(
  input  pinvec_t dir,
  input  pinvec_t outv,
  input  pinvec_t hiz,
  input  pinvec_t pen,
  input  pinvec_t psel,
  output pinvec_t pin_oe,
  output pinvec_t pin_out,
  output pinvec_t pull_en,
  output pinvec_t pull_up
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic drv, pl;
    assign drv        = dir[i] & ~hiz[i];
    assign pl         = ~dir[i] & pen[i];
    assign pin_oe[i]  = drv;
    assign pin_out[i] = drv & outv[i];
    assign pull_en[i] = pl;
    assign pull_up[i] = pl & psel[i];
  end
endmodule

// File: rtl/gpio_xpdr_irq.sv
module gpio_xpdr_irq
  import gpio_xpdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t lvl,
  input  pinvec_t expv,
  input  pinvec_t mask,
  input  logic    clr_stat,
  input  logic    clr_flag,
  input  logic    soft_rst,
  output pinvec_t stat_o,
  output logic    flag_o,
  output logic    irq_n
);
  pinvec_t stat_d, stat_q, miss;
  logic    flag_d, flag_q;

  assign miss = lvl ^ expv;

  always_comb begin
    stat_d = stat_q;
    flag_d = flag_q;
    if (soft_rst) begin
      stat_d = '0;
      flag_d = 1'b1;
    end else begin
      stat_d = (clr_stat ? '0 : stat_q) | miss;
      if (clr_flag) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      flag_q <= 1'b1;
    end else begin
      stat_q <= stat_d;
      flag_q <= flag_d;
    end
  end

  assign stat_o = stat_q;
  assign flag_o = flag_q;
  assign irq_n  = ~((|(stat_q & ~mask)) | flag_q);
endmodule

// File: rtl/gpio_xpdr_core.sv
module gpio_xpdr_core
  import gpio_xpdr_pkg::*;
#(
  parameter logic [2:0] REV = 3'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic [7:0] pull_en,
  output logic [7:0] pull_up,
  output logic       irq_n
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [NREG-1:0][NPIN-1:0] cfg;
  pinvec_t ins_lvl, stat_q;
  logic    por_flag, soft_rst, clr_stat, clr_flag;

  assign soft_rst = reg_wr && (reg_addr == A_ID) && reg_wdata[0];
  assign clr_stat = reg_rd && (reg_addr == A_STAT);
  assign clr_flag = reg_rd && (reg_addr == A_ID);

  gpio_xpdr_regs u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .soft_rst (soft_rst),
    .cfg_o    (cfg)
  );

  gpio_xpdr_sync #(.W(NPIN), .STAGES(2), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (pin_in),
    .q_o   (ins_lvl)
  );

  gpio_xpdr_pins u_pins (
    .dir     (cfg[I_DIR]),
    .outv    (cfg[I_OUT]),
    .hiz     (cfg[I_HIZ]),
    .pen     (cfg[I_PEN]),
    .psel    (cfg[I_PSEL]),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .pull_en (pull_en),
    .pull_up (pull_up)
  );

  gpio_xpdr_irq u_irq (
    .clk      (clk),
    .rst_n    (srst_n),
    .lvl      (ins_lvl),
    .expv     (cfg[I_EXP]),
    .mask     (cfg[I_MASK]),
    .clr_stat (clr_stat),
    .clr_flag (clr_flag),
    .soft_rst (soft_rst),
    .stat_o   (stat_q),
    .flag_o   (por_flag),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_ID)         reg_rdata = {MFR_CODE, REV, por_flag, 1'b0};
    else if (reg_addr == A_INSTS) reg_rdata = ins_lvl;
    else if (reg_addr == A_STAT)  reg_rdata = stat_q;
    else begin
      for (int k = 0; k < NREG; k++) begin
        if (reg_addr == slot_addr(k)) reg_rdata = cfg[k];
      end
    end
  end
endmodule

// File: rtl/gpio_xpdr_chk.sv
module gpio_xpdr_chk
  import gpio_xpdr_pkg::*;
(
  input logic    clk,
  input logic    srst_n,
  input logic    reg_wr,
  input logic    reg_rd,
  input addr_t   reg_addr,
  input pinvec_t reg_wdata,
  input pinvec_t dir,
  input pinvec_t mask,
  input pinvec_t expv,
  input pinvec_t lvl,
  input pinvec_t stat,
  input logic    flag,
  input pinvec_t pin_oe,
  input pinvec_t pull_en,
  input logic    irq_n
);
  logic srst_w;
  assign srst_w = reg_wr && (reg_addr == A_ID) && reg_wdata[0];

  AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (!srst_n)
    (pin_oe & ~dir) == '0); // R2
  AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!srst_n)
    (pull_en & dir) == '0); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (!(reg_rd && reg_addr == A_STAT) && !srst_w) |=> (($past(stat) & ~stat) == '0)); // R5
  AST_CLEAR_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == A_STAT && !srst_w) |=> (stat == $past(lvl ^ expv))); // R6
  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!srst_n)
    ((stat & ~mask) != '0) |-> !irq_n); // R7
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    flag |-> !irq_n); // R8
  AST_ID_READ_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rd && reg_addr == A_ID && !srst_w) |=> !flag); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!srst_n)
    srst_w |=> (dir == '0 && mask == '1 && stat == '0 && flag)); // R10
endmodule

bind gpio_xpdr_core gpio_xpdr_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dir       (cfg[0]),
  .mask      (cfg[6]),
  .expv      (cfg[3]),
  .lvl       (ins_lvl),
  .stat      (stat_q),
  .flag      (por_flag),
  .pin_oe    (pin_oe),
  .pull_en   (pull_en),
  .irq_n     (irq_n)
);

// File: tb/gpio_xpdr_core_bench.sv
`timescale 1ns/1ps
module gpio_xpdr_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] pin_in, pin_oe, pin_out, pull_en, pull_up;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_xpdr_core u_gpio_xpdr_core (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .irq_n(irq_n)
  );

  localparam logic [7:0] RW_ADDR [7] = '{8'h03, 8'h05, 8'h07, 8'h09, 8'h0B, 8'h0D, 8'h11};
  localparam logic [7:0] RW_DFLT [7] = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, e;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    pin_in = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R3 reset values and pin outputs
    for (int k = 0; k < 7; k++) begin
      rd(RW_ADDR[k], v);
      chk("R3 reset value", v, RW_DFLT[k]);
    end
    rd(8'h13, v);       chk("R3 status reset", v, 8'h00);
    chk("R3 pin_oe", pin_oe, 8'h00);
    chk("R3 pull_en", pull_en, 8'hFF);
    chk("R3 pull_up", pull_up, 8'hFF);

    // R8 flag after reset, R9 ID fields and clear on read
    chk("R8 irq_n with flag", {7'd0, irq_n}, 8'h00);
    rd(8'h01, v);       chk("R9 id with flag", v, 8'hA6);
    rd(8'h01, v);       chk("R9 id flag cleared", v, 8'hA4);
    chk("R8 irq_n released", {7'd0, irq_n}, 8'h01);

    // R1 readback sweep on every read/write register
    for (int k = 0; k < 7; k++) begin
      for (int x = 0; x < 256; x++) begin
        wr(RW_ADDR[k], 8'(x));
        rd(RW_ADDR[k], v);
        chk("R1 readback", v, 8'(x));
      end
    end
    wr(8'h01, 8'h01);
    rd(8'h01, v);

    // R2 and R4 exhaustive sweep over the direction pattern
    for (int x = 0; x < 256; x++) begin
      logic [7:0] d, o, h, p, m;
      d = 8'(x); o = d ^ 8'h5A; h = {d[3:0], d[7:4]}; p = ~{d[0], d[7:1]}; m = d ^ 8'h33;
      wr(8'h03, d); wr(8'h05, o); wr(8'h07, h); wr(8'h0B, p); wr(8'h0D, m);
      #1;
      chk("R2 pin_oe", pin_oe, d & ~h);
      chk("R2 pin_out", pin_out, d & ~h & o);
      chk("R4 pull_en", pull_en, ~d & p);
      chk("R4 pull_up", pull_up, ~d & p & m);
    end

    // R10 soft reset after non-default settings
    wr(8'h11, 8'h00);
    rd(8'h01, v);
    wr(8'h01, 8'h03);
    chk("R10 irq_n low from flag", {7'd0, irq_n}, 8'h00);
    for (int k = 0; k < 7; k++) begin
      rd(RW_ADDR[k], v);
      chk("R10 restored", v, RW_DFLT[k]);
    end
    rd(8'h01, v);       chk("R10 flag set again", v, 8'hA6);

    // R5 input level sweep with expected 0xFF: sync view and status
    for (int x = 0; x < 256; x++) begin
      @(negedge clk) pin_in = 8'(x);
      idle(3);
      rd(8'h0F, v);     chk("R5 input level", v, 8'(x));
      rd(8'h13, v);
      rd(8'h13, v);     chk("R5 R6 live mismatch status", v, ~8'(x));
    end
    @(negedge clk) pin_in = 8'hFF;
    idle(3);
    rd(8'h13, v); rd(8'h13, v);
    chk("R5 status clean", v, 8'h00);

    // R5 two-edge latency, R7 interrupt on unmasked pin 0
    wr(8'h11, 8'hFE);
    @(negedge clk) pin_in = 8'hFE;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R5 irq after two edges", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    #1 chk("R7 irq after three edges", {7'd0, irq_n}, 8'h00);
    // R6 clearing read while mismatch is live
    rd(8'h13, v);       chk("R6 first read", v, 8'h01);
    rd(8'h13, v);       chk("R6 bit set again", v, 8'h01);
    @(negedge clk) pin_in = 8'hFF;
    idle(3);
    chk("R5 sticky irq", {7'd0, irq_n}, 8'h00);
    rd(8'h13, v);       chk("R5 sticky status", v, 8'h01);
    rd(8'h13, v);       chk("R6 cleared", v, 8'h00);
    chk("R7 irq released", {7'd0, irq_n}, 8'h01);

    // R7 masked pin sets status but not the interrupt
    @(negedge clk) pin_in = 8'hF7;
    idle(4);
    chk("R7 masked pin irq", {7'd0, irq_n}, 8'h01);
    @(negedge clk) pin_in = 8'hFF;
    idle(3);
    rd(8'h13, v);       chk("R7 masked status", v, 8'h08);
    // R7 expected level low, pin low is no mismatch; pin high is
    wr(8'h09, 8'hFE);
    @(negedge clk) pin_in = 8'hFE;
    idle(3);
    rd(8'h13, v); rd(8'h13, v);
    chk("R7 expected low match", v, 8'h00);
    chk("R7 irq idle", {7'd0, irq_n}, 8'h01);
    wr(8'h09, 8'hFF);
    idle(1);
    chk("R7 expected change irq", {7'd0, irq_n}, 8'h00);
    @(negedge clk) pin_in = 8'hFF;
    idle(3);
    rd(8'h13, v); rd(8'h13, v);

    // R11 ignored writes and unmapped reads
    wr(8'h0F, 8'h00);
    wr(8'h13, 8'hFF);
    wr(8'h20, 8'h55);
    wr(8'h02, 8'h55);
    rd(8'h13, v);       chk("R11 status untouched", v, 8'h00);
    rd(8'h0F, v);       chk("R11 input untouched", v, 8'hFF);
    rd(8'h11, v);       chk("R11 mask untouched", v, 8'hFE);
    rd(8'h03, v);       chk("R11 dir untouched", v, 8'h00);
    chk("R11 irq high", {7'd0, irq_n}, 8'h01);
    rd(8'h20, v);       chk("R11 unmapped read", v, 8'h00);
    rd(8'h02, v);       chk("R11 unmapped read even", v, 8'h00);
    wr(8'h01, 8'h00);
    rd(8'h03, v);       chk("R10 write without bit0", v, 8'h00);
    rd(8'h01, v);       chk("R9 no flag without bit0", v, 8'hA4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule